// File: doc/BRIEF.md
# Privilege-Checked Interrupt Controller Register Block

This block is the memory-mapped register file of a vectored interrupt controller. It sits on a simple single-cycle bus that carries an address, write data, a byte count, a write flag and an unprivileged-access attribute. It holds the enable, pending, active and priority state of every external interrupt, plus twelve system-handler priority bytes. It presents that state through set and clear aliases, byte-addressed priority registers and a software trigger register.

Every access is checked against a privilege policy before it can take effect. Unprivileged code is locked out of the whole block and receives a bus error. The only exception is the software trigger register, which a control bit can open to unprivileged writers. A combinational output names the pending, enabled, not-active interrupt that should be serviced next. A one-cycle acknowledge moves that interrupt from pending to active, and a completion strobe retires an active interrupt.

Top module: `irq_priv_regs`

## Requirements
- R1: An unprivileged access (`bus_user`=1) to any address other than 0xF00 gets `bus_err`=1 and `bus_rdata`=0, and it changes no state.
- R2: An unprivileged access to 0xF00 is accepted only while bit 1 of the control word at 0xD14 is 1; otherwise it gets `bus_err`=1. The control word is a 4-byte register, reads back {30'b0, bit1, 1'b0} and resets to 0.
- R3: A 4-byte write to 0xF00 takes v = `bus_wdata[8:0]` (exception number v+16) and sets pending bit v only when v < NIRQ; otherwise it is ignored. Reads of 0xF00 return 0.
- R4: The enable-set alias is at 0x100–0x13F and the enable-clear alias at 0x180–0x1BF. Bit n sits at byte offset n/8, bit n%8, and byte lane i of the data maps to byte offset (addr−base)+i. Both aliases read the enable bits. A 1 sets the bit (set alias) or clears it (clear alias), and a 0 has no effect. Bits n ≥ NIRQ read 0.
- R5: The pending bits have the same layout and alias behaviour, with the set alias at 0x200–0x23F and the clear alias at 0x280–0x2BF.
- R6: The active bits at 0x300–0x33F (same layout) are read-only. Writes there complete with `bus_err`=0 and change nothing.
- R7: Priority byte of interrupt n is at 0x400+n (region end 0x5EF). An access of N bytes at address a covers interrupts (a−0x400)+i through byte lane i. Bytes for n ≥ NIRQ read 0 and ignore writes.
- R8: System-handler priority bytes are at 0xD18–0xD23. A byte at address o is handler index o−0xD14 (4..15) and reads back what was written, with byte lane i at o+i.
- R9: Sizes other than 1, 2 or 4 bytes, sizes other than 4 at 0xD14 and 0xF00, and unmapped addresses all complete with `bus_err`=0. Such reads return 0 and such writes are ignored.
- R10: `bus_err` and `bus_rdata` answer in the same cycle as the access. A write is visible to an access in the following cycle.
- R11: `best_valid`/`best_id` name the pending, enabled, not-active interrupt with the lowest priority value, with ties going to the lowest number. `best_valid`=0 when there is none.
- R12: `ack`=1 with `best_valid`=1 clears the pending bit and sets the active bit of `best_id` at the clock edge. `done_valid`=1 clears the active bit of `done_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | 1 = unprivileged access |
| bus_addr | input | 12 | Byte offset within the block |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, lane 0 = lowest address |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | 1 = bus error response, same cycle |
| ack | input | 1 | Take the current best interrupt |
| done_valid | input | 1 | Retire an active interrupt |
| done_id | input | IDW | Interrupt to retire |
| best_valid | output | 1 | A candidate exists |
| best_id | output | IDW | Winning interrupt number |

## Verification
The selector is tried with a single candidate, with several candidates of distinct priority, and with an exact priority tie. This separates a lowest-value comparison from a lowest-number fallback. It is then tried with candidates removed by disabling, by clearing pending and by going active, which shows that all three masks take part in the choice. The privilege gate is tried with the trigger enable both closed and open, and with unprivileged accesses to neighbouring offsets, so a gate that checks only the region or only the control bit is caught. Byte-lane accesses at unaligned addresses and at the top of the implemented range show that the lane mapping and the limit checks are distinct from whole-word behaviour.

// File: rtl/irqr_pkg.sv
// Shared definitions for the privilege-checked interrupt register block.
// Assumes a 12-bit byte offset bus and byte-wide priority fields.
package irqr_pkg;
    typedef enum logic [3:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACT,
        RG_PRIO,
        RG_CTRL,
        RG_SHP,
        RG_TRIG
    } region_t;

    localparam int          PRIO_W    = 8;
    localparam int          BMAP_BITS = 512;   // 64 bytes of bitmap alias space
    localparam int          SHP_NUM   = 12;    // handler indices 4..15
    localparam logic [11:0] A_EN_SET  = 12'h100;
    localparam logic [11:0] A_EN_CLR  = 12'h180;
    localparam logic [11:0] A_PD_SET  = 12'h200;
    localparam logic [11:0] A_PD_CLR  = 12'h280;
    localparam logic [11:0] A_ACT     = 12'h300;
    localparam logic [11:0] BMAP_LAST = 12'h03F;
    localparam logic [11:0] A_PRIO    = 12'h400;
    localparam logic [11:0] A_PRIO_E  = 12'h5EF;
    localparam logic [11:0] A_CTRL    = 12'hD14;
    localparam logic [11:0] A_SHP     = 12'hD18;
    localparam logic [11:0] A_SHP_E   = 12'hD23;
    localparam logic [11:0] A_TRIG    = 12'hF00;
endpackage

// File: rtl/irqr_decode.sv
// Address decoder and privilege gate.
// Maps a bus offset to a region and a byte offset within it, derives the
// byte-lane mask from the size, decides whether the size fits the region,
// and denies unprivileged accesses except an opened trigger register.
// Purely combinational; assumes addresses are byte offsets into the block.
module irqr_decode
    import irqr_pkg::*;
(
    input  logic [11:0] addr,
    input  logic [2:0]  size,
    input  logic        user,
    input  logic        utrig_en,
    output region_t     region,
    output logic [8:0]  off,
    output logic [3:0]  lanes,
    output logic        fit,
    output logic        deny
);
    // Region and in-region offset from the address.
    always_comb begin
        region = RG_NONE;
        off    = '0;
        if (addr >= A_EN_SET && addr <= A_EN_SET + BMAP_LAST) begin
            region = RG_EN_SET; off = 9'(addr - A_EN_SET);
        end else if (addr >= A_EN_CLR && addr <= A_EN_CLR + BMAP_LAST) begin
            region = RG_EN_CLR; off = 9'(addr - A_EN_CLR);
        end else if (addr >= A_PD_SET && addr <= A_PD_SET + BMAP_LAST) begin
            region = RG_PD_SET; off = 9'(addr - A_PD_SET);
        end else if (addr >= A_PD_CLR && addr <= A_PD_CLR + BMAP_LAST) begin
            region = RG_PD_CLR; off = 9'(addr - A_PD_CLR);
        end else if (addr >= A_ACT && addr <= A_ACT + BMAP_LAST) begin
            region = RG_ACT; off = 9'(addr - A_ACT);
        end else if (addr >= A_PRIO && addr <= A_PRIO_E) begin
            region = RG_PRIO; off = 9'(addr - A_PRIO);
        end else if (addr == A_CTRL) begin
            region = RG_CTRL;
        end else if (addr >= A_SHP && addr <= A_SHP_E) begin
            region = RG_SHP; off = 9'(addr - A_SHP);
        end else if (addr == A_TRIG) begin
            region = RG_TRIG;
        end
    end

    // Byte-lane mask for the supported sizes.
    always_comb begin
        case (size)
            3'd1:    lanes = 4'b0001;
            3'd2:    lanes = 4'b0011;
            3'd4:    lanes = 4'b1111;
            default: lanes = 4'b0000;
        endcase
    end

    // Size legality per region; word-only registers need exactly 4 bytes.
    always_comb begin
        case (region)
            RG_NONE:         fit = 1'b0;
            RG_CTRL, RG_TRIG: fit = (size == 3'd4);
            default:         fit = (lanes != 4'b0000);
        endcase
    end

    // Privilege policy: unprivileged only to an opened trigger register.
    assign deny = user && !(region == RG_TRIG && utrig_en);
endmodule

// File: rtl/irqr_state.sv
// Interrupt state bank.
// Holds enable, pending, active and priority for NIRQ external interrupts
// plus the system-handler priority bytes, and applies byte-lane writes,
// trigger writes and take/retire events. Assumes the caller has already
// gated wr with the privilege and size checks. Synchronous active-low reset.
module irqr_state
    import irqr_pkg::*;
#(
    parameter int NIRQ = 32,
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  region_t                        region,
    input  logic [8:0]                     off,
    input  logic [3:0]                     lanes,
    input  logic [31:0]                    wdata,
    input  logic                           take,
    input  logic [IDW-1:0]                 take_id,
    input  logic                           drop,
    input  logic [IDW-1:0]                 drop_id,
    output logic [NIRQ-1:0]                en_q,
    output logic [NIRQ-1:0]                pend_q,
    output logic [NIRQ-1:0]                act_q,
    output logic [NIRQ-1:0][PRIO_W-1:0]    prio_q,
    output logic [SHP_NUM-1:0][PRIO_W-1:0] shp_q
);
    localparam logic [NIRQ-1:0] ONE = {{(NIRQ-1){1'b0}}, 1'b1};

    logic [31:0]                    lane32;
    logic [BMAP_BITS-1:0]           wide;
    logic [NIRQ-1:0]                hit;
    logic [NIRQ-1:0]                trig_hit;
    logic [NIRQ-1:0]                en_n, pend_n, act_n;
    logic [NIRQ-1:0][PRIO_W-1:0]    prio_n;
    logic [SHP_NUM-1:0][PRIO_W-1:0] shp_n;

    // Place masked write data onto the bitmap at the addressed byte offset.
    always_comb begin
        lane32 = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
        wide   = BMAP_BITS'(wdata & lane32) << {off[5:0], 3'b000};
        hit    = wide[NIRQ-1:0];
    end

    // Decode a trigger write into a one-hot pending request, range-checked.
    always_comb begin
        trig_hit = '0;
        if (wr && region == RG_TRIG && {1'b0, wdata[8:0]} < 10'(NIRQ))
            trig_hit = ONE << wdata[8:0];
    end

    // Next enable, pending and active bits.
    always_comb begin
        en_n   = en_q;
        pend_n = pend_q;
        act_n  = act_q;
        if (drop)
            act_n = act_n & ~(ONE << drop_id);
        if (take) begin
            act_n  = act_n | (ONE << take_id);
            pend_n = pend_n & ~(ONE << take_id);
        end
        if (wr && region == RG_EN_SET) en_n   = en_n | hit;
        if (wr && region == RG_EN_CLR) en_n   = en_n & ~hit;
        if (wr && region == RG_PD_SET) pend_n = pend_n | hit;
        if (wr && region == RG_PD_CLR) pend_n = pend_n & ~hit;
        pend_n = pend_n | trig_hit;
    end

    // Next priority bytes: lane d of the data goes to interrupt off+d.
    always_comb begin
        prio_n = prio_q;
        for (int n = 0; n < NIRQ; n++) begin
            logic [9:0] d;
            d = 10'(n) - {1'b0, off};
            if (wr && region == RG_PRIO && d < 10'd4 && lanes[d[1:0]])
                prio_n[n] = wdata[{d[1:0], 3'b000} +: 8];
        end
    end

    // Next system-handler priority bytes, same lane rule.
    always_comb begin
        shp_n = shp_q;
        for (int k = 0; k < SHP_NUM; k++) begin
            logic [9:0] d;
            d = 10'(k) - {1'b0, off};
            if (wr && region == RG_SHP && d < 10'd4 && lanes[d[1:0]])
                shp_n[k] = wdata[{d[1:0], 3'b000} +: 8];
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            prio_q <= '0;
            shp_q  <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
            act_q  <= act_n;
            prio_q <= prio_n;
            shp_q  <= shp_n;
        end
    end

    // R6: writes to the active region leave the active bits alone.
    p_act_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_ACT && !take && !drop) |=> $stable(act_q));

    // R3: an out-of-range trigger number sets nothing.
    p_trig_oob_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_TRIG && {1'b0, wdata[8:0]} >= 10'(NIRQ) && !take)
        |=> $stable(pend_q));

    // R12: a taken interrupt is active and no longer pending.
    p_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> (act_q[$past(take_id)] && !pend_q[$past(take_id)]));
endmodule

// File: rtl/irqr_rdmux.sv
// Read-data multiplexer.
// Presents bitmap aliases, priority bytes, handler bytes and the control
// word on 32 bits, honouring the byte lanes. Unused lanes and
// unmapped or write-only registers read as zero. Purely combinational.
module irqr_rdmux
    import irqr_pkg::*;
#(
    parameter int NIRQ = 32
) (
    input  region_t                        region,
    input  logic [8:0]                     off,
    input  logic [3:0]                     lanes,
    input  logic [NIRQ-1:0]                en_q,
    input  logic [NIRQ-1:0]                pend_q,
    input  logic [NIRQ-1:0]                act_q,
    input  logic [NIRQ-1:0][PRIO_W-1:0]    prio_q,
    input  logic [SHP_NUM-1:0][PRIO_W-1:0] shp_q,
    input  logic                           utrig_q,
    output logic [31:0]                    rdata
);
    logic [31:0]          lane32;
    logic [NIRQ-1:0]      vec;
    logic [BMAP_BITS-1:0] wide;
    logic [3:0][7:0]      pb, sb;

    // Pick the bitmap behind the addressed alias and slide it to the offset.
    always_comb begin
        case (region)
            RG_EN_SET, RG_EN_CLR: vec = en_q;
            RG_PD_SET, RG_PD_CLR: vec = pend_q;
            RG_ACT:               vec = act_q;
            default:              vec = '0;
        endcase
        wide = BMAP_BITS'(vec) >> {off[5:0], 3'b000};
    end

    // Gather priority and handler bytes into lanes.
    always_comb begin
        pb = '0;
        sb = '0;
        for (int n = 0; n < NIRQ; n++) begin
            logic [9:0] d;
            d = 10'(n) - {1'b0, off};
            if (d < 10'd4) pb[d[1:0]] = prio_q[n];
        end
        for (int k = 0; k < SHP_NUM; k++) begin
            logic [9:0] d;
            d = 10'(k) - {1'b0, off};
            if (d < 10'd4) sb[d[1:0]] = shp_q[k];
        end
    end

    // Final selection and lane masking.
    always_comb begin
        lane32 = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
        case (region)
            RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_ACT:
                     rdata = wide[31:0] & lane32;
            RG_PRIO: rdata = pb & lane32;
            RG_SHP:  rdata = sb & lane32;
            RG_CTRL: rdata = {30'b0, utrig_q, 1'b0};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqr_pick.sv
// Next-interrupt selector.
// Finds the pending, enabled, not-active interrupt with the lowest priority
// value; ties go to the lowest number. Combinational; clk and rst_n only
// qualify the assertions.
module irqr_pick
    import irqr_pkg::*;
#(
    parameter int NIRQ = 32,
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NIRQ-1:0]             en_q,
    input  logic [NIRQ-1:0]             pend_q,
    input  logic [NIRQ-1:0]             act_q,
    input  logic [NIRQ-1:0][PRIO_W-1:0] prio_q,
    output logic                        best_valid,
    output logic [IDW-1:0]              best_id
);
    logic [NIRQ-1:0]   cand;
    logic [PRIO_W-1:0] bprio;

    assign cand = pend_q & en_q & ~act_q;

    // Linear scan; strict less-than keeps the earliest of equal priorities.
    always_comb begin
        best_valid = 1'b0;
        best_id    = '0;
        bprio      = '0;
        for (int n = 0; n < NIRQ; n++) begin
            if (cand[n] && (!best_valid || prio_q[n] < bprio)) begin
                best_valid = 1'b1;
                best_id    = IDW'(n);
                bprio      = prio_q[n];
            end
        end
    end

    // R11: the reported winner is a real candidate.
    p_best_cand_r11: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> (pend_q[best_id] && en_q[best_id] && !act_q[best_id]));

    // R11: no winner only when nothing qualifies.
    p_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid |-> ($countones(pend_q & en_q & ~act_q) == 0));

    // R11: no candidate beats the winner on priority or on number.
    always @(posedge clk) begin
        if (rst_n && best_valid) begin
            for (int n = 0; n < NIRQ; n++) begin
                p_min_r11: assert (!(pend_q[n] && en_q[n] && !act_q[n] &&
                    (prio_q[n] < prio_q[best_id] ||
                     (prio_q[n] == prio_q[best_id] && n < int'(best_id)))));
            end
        end
    end
endmodule

// File: rtl/irq_priv_regs.sv
// Privilege-checked interrupt controller register block (top).
// Single-cycle bus: error and read data answer combinationally in the
// access cycle, writes land at the next clock edge. Holds the trigger
// access control bit. Synchronous active-low reset.
module irq_priv_regs
    import irqr_pkg::*;
#(
    parameter int NIRQ = 32,
    localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic           bus_user,
    input  logic [11:0]    bus_addr,
    input  logic [2:0]     bus_size,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           bus_err,
    input  logic           ack,
    input  logic           done_valid,
    input  logic [IDW-1:0] done_id,
    output logic           best_valid,
    output logic [IDW-1:0] best_id
);
    region_t                        region;
    logic [8:0]                     off;
    logic [3:0]                     lanes;
    logic                           fit, deny, wr, rd_ok, take, utrig_q;
    logic [31:0]                    rd_mux;
    logic [NIRQ-1:0]                en_q, pend_q, act_q;
    logic [NIRQ-1:0][PRIO_W-1:0]    prio_q;
    logic [SHP_NUM-1:0][PRIO_W-1:0] shp_q;

    irqr_decode u_dec (
        .addr(bus_addr), .size(bus_size), .user(bus_user), .utrig_en(utrig_q),
        .region(region), .off(off), .lanes(lanes), .fit(fit), .deny(deny)
    );

    // Bus response qualification.
    assign bus_err = bus_valid && deny;
    assign wr      = bus_valid && bus_write && !deny && fit;
    assign rd_ok   = bus_valid && !bus_write && !deny && fit;
    assign take    = ack && best_valid;

    irqr_state #(.NIRQ(NIRQ)) u_state (
        .clk(clk), .rst_n(rst_n), .wr(wr), .region(region), .off(off),
        .lanes(lanes), .wdata(bus_wdata), .take(take), .take_id(best_id),
        .drop(done_valid), .drop_id(done_id), .en_q(en_q), .pend_q(pend_q),
        .act_q(act_q), .prio_q(prio_q), .shp_q(shp_q)
    );

    irqr_rdmux #(.NIRQ(NIRQ)) u_rd (
        .region(region), .off(off), .lanes(lanes), .en_q(en_q),
        .pend_q(pend_q), .act_q(act_q), .prio_q(prio_q), .shp_q(shp_q),
        .utrig_q(utrig_q), .rdata(rd_mux)
    );

    irqr_pick #(.NIRQ(NIRQ)) u_pick (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .pend_q(pend_q),
        .act_q(act_q), .prio_q(prio_q), .best_valid(best_valid),
        .best_id(best_id)
    );

    // Read data only for accepted, well-sized reads.
    assign bus_rdata = rd_ok ? rd_mux : 32'h0;

    // Control word: bit 1 opens the trigger register to unprivileged code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            utrig_q <= 1'b0;
        else if (wr && region == RG_CTRL)
            utrig_q <= bus_wdata[1];
    end

    // R1: unprivileged access away from the trigger offset is refused.
    p_user_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_user && bus_addr != A_TRIG) |-> bus_err);

    // R2: closed trigger register refuses unprivileged access.
    p_trig_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_user && bus_addr == A_TRIG && !utrig_q) |-> bus_err);

    // R10: an error response carries no data.
    p_err_rdzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'h0));

    // R1: a refused access leaves every piece of state unchanged.
    p_denied_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_err && !ack && !done_valid) |=>
        ($stable(en_q) && $stable(pend_q) && $stable(act_q) &&
         $stable(prio_q) && $stable(shp_q) && $stable(utrig_q)));
endmodule

// File: tb/tb_irq_priv_regs.sv
`timescale 1ns/1ps
module tb_irq_priv_regs;
    localparam int NIRQ = 32;
    localparam int IDW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_valid = 1'b0, bus_write = 1'b0, bus_user = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [2:0]     bus_size = 3'd4;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           bus_err;
    logic           ack = 1'b0, done_valid = 1'b0;
    logic [IDW-1:0] done_id = '0;
    logic           best_valid;
    logic [IDW-1:0] best_id;
    logic           probe = 1'b0;

    always #2.5 clk = ~clk;

    irq_priv_regs #(.NIRQ(NIRQ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_user(bus_user), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .ack(ack), .done_valid(done_valid), .done_id(done_id),
        .best_valid(best_valid), .best_id(best_id)
    );

    typedef struct {
        int          kind;   // 0 = bus response, 1 = best output
        logic [31:0] d;
        logic        e;
        logic        chkd;
        logic        bv;
        int          bid;
    } item_t;

    item_t q[$];
    string tq[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    // Monitor: pop one expectation per probed cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (probe && q.size() > 0) begin
                item_t it;
                string tg;
                it = q.pop_front();
                tg = tq.pop_front();
                n_cmp++;
                if (it.kind == 0) begin
                    if (bus_err !== it.e || (it.chkd && bus_rdata !== it.d)) begin
                        n_bad++;
                        $display("FAIL %s: err=%0d data=%h, expected err=%0d data=%h",
                                 tg, bus_err, bus_rdata, it.e, it.d);
                    end
                end else begin
                    if (best_valid !== it.bv || (it.bv && int'(best_id) != it.bid)) begin
                        n_bad++;
                        $display("FAIL %s: best_valid=%0d best_id=%0d, expected %0d/%0d",
                                 tg, best_valid, best_id, it.bv, it.bid);
                    end
                end
            end
        end
    end

    task automatic push(int kind, logic [31:0] d, logic e, logic chkd,
                        logic bv, int bid, string tg);
        item_t it;
        it.kind = kind; it.d = d; it.e = e; it.chkd = chkd; it.bv = bv; it.bid = bid;
        q.push_back(it);
        tq.push_back(tg);
    endtask

    task automatic rd(logic [11:0] a, logic [2:0] sz, logic u,
                      logic [31:0] exp_d, logic exp_e, string tg);
        @(negedge clk);
        ack = 0; done_valid = 0;
        bus_valid = 1; bus_write = 0; bus_user = u; bus_addr = a; bus_size = sz;
        bus_wdata = '0; probe = 1;
        push(0, exp_d, exp_e, 1'b1, 1'b0, 0, tg);
    endtask

    task automatic wr(logic [11:0] a, logic [2:0] sz, logic [31:0] dat,
                      logic u, logic exp_e, string tg);
        @(negedge clk);
        ack = 0; done_valid = 0;
        bus_valid = 1; bus_write = 1; bus_user = u; bus_addr = a; bus_size = sz;
        bus_wdata = dat; probe = 1;
        push(0, 32'h0, exp_e, 1'b0, 1'b0, 0, tg);
    endtask

    task automatic best(logic v, int id, string tg);
        @(negedge clk);
        ack = 0; done_valid = 0; bus_valid = 0; probe = 1;
        push(1, 32'h0, 1'b0, 1'b0, v, id, tg);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        bus_valid = 0; done_valid = 0; ack = 1; probe = 0;
    endtask

    task automatic pulse_done(int id);
        @(negedge clk);
        bus_valid = 0; ack = 0; done_valid = 1; done_id = IDW'(id); probe = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 0; ack = 0; done_valid = 0; probe = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Driver: stimulus with expected values worked out from the requirements.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // Reset state
        rd(12'h100, 4, 0, 32'h0, 0, "R4 reset enables");
        rd(12'h200, 4, 0, 32'h0, 0, "R5 reset pending");
        rd(12'h300, 4, 0, 32'h0, 0, "R6 reset active");
        best(0, 0, "R11 reset no winner");

        // R4 enable aliases
        wr(12'h100, 4, 32'h0000_00F3, 0, 0, "R4 set write");
        rd(12'h100, 4, 0, 32'h0000_00F3, 0, "R10 R4 set visible next cycle");
        rd(12'h180, 4, 0, 32'h0000_00F3, 0, "R4 clear alias reads enables");
        wr(12'h180, 4, 32'h0000_0011, 0, 0, "R4 clear write");
        rd(12'h100, 4, 0, 32'h0000_00E2, 0, "R4 clear ones");
        wr(12'h100, 4, 32'h0, 0, 0, "R4 zero write");
        rd(12'h100, 4, 0, 32'h0000_00E2, 0, "R4 zeros no effect");
        wr(12'h101, 1, 32'h0000_0005, 0, 0, "R4 byte write");
        rd(12'h100, 4, 0, 32'h0000_05E2, 0, "R4 byte lane placement");
        rd(12'h101, 1, 0, 32'h0000_0005, 0, "R4 byte read");
        rd(12'h104, 4, 0, 32'h0, 0, "R4 unimplemented bits zero");

        // R5 pending aliases
        wr(12'h200, 4, 32'h0000_0030, 0, 0, "R5 set");
        rd(12'h280, 4, 0, 32'h0000_0030, 0, "R5 clear alias reads");
        wr(12'h280, 4, 32'h0000_0010, 0, 0, "R5 clear");
        rd(12'h200, 4, 0, 32'h0000_0020, 0, "R5 after clear");

        // R7 priority bytes
        wr(12'h400, 4, 32'h4030_2010, 0, 0, "R7 word write");
        rd(12'h401, 2, 0, 32'h0000_3020, 0, "R7 unaligned half read");
        wr(12'h405, 1, 32'h0000_0007, 0, 0, "R7 byte write");
        rd(12'h404, 4, 0, 32'h0000_0700, 0, "R7 byte lane mapping");
        wr(12'h41F, 4, 32'hAABB_CC55, 0, 0, "R7 write past last");
        rd(12'h41C, 4, 0, 32'h5500_0000, 0, "R7 top interrupt only");
        rd(12'h420, 4, 0, 32'h0, 0, "R7 unimplemented reads zero");

        // R11 selection
        wr(12'h100, 4, 32'hFFFF_FFFF, 0, 0, "R4 enable all");
        best(1, 5, "R11 single candidate");
        wr(12'h200, 4, 32'h0000_0003, 0, 0, "R5 pend 0,1");
        best(1, 5, "R11 lowest value wins");
        wr(12'h405, 1, 32'h0000_0020, 0, 0, "R7 raise prio 5");
        best(1, 0, "R11 reorder");
        wr(12'h401, 1, 32'h0000_0010, 0, 0, "R7 tie prio 1");
        best(1, 0, "R11 tie lowest number");
        wr(12'h280, 4, 32'h0000_0001, 0, 0, "R5 clear 0");
        best(1, 1, "R11 pending mask");
        wr(12'h180, 4, 32'h0000_0002, 0, 0, "R4 disable 1");
        best(1, 5, "R11 enable mask");

        // R12 acknowledge and retire
        pulse_ack();
        rd(12'h300, 4, 0, 32'h0000_0020, 0, "R12 ack sets active");
        rd(12'h200, 4, 0, 32'h0000_0002, 0, "R12 ack clears pending");
        best(0, 0, "R11 active and disabled excluded");
        wr(12'h300, 4, 32'h0, 0, 0, "R6 write to active ok");
        rd(12'h300, 4, 0, 32'h0000_0020, 0, "R6 active unchanged");
        wr(12'h100, 4, 32'h0000_0002, 0, 0, "R4 enable 1");
        best(1, 1, "R11 winner 1");
        wr(12'h200, 4, 32'h0000_0020, 0, 0, "R5 re-pend 5");
        best(1, 1, "R11 active mask");
        pulse_done(5);
        best(1, 1, "R12 after retire");
        rd(12'h300, 4, 0, 32'h0, 0, "R12 done clears active");
        wr(12'h280, 4, 32'h0000_0002, 0, 0, "R5 clear 1");
        best(1, 5, "R11 retired becomes eligible");
        wr(12'h280, 4, 32'hFFFF_FFFF, 0, 0, "R5 clear all");
        best(0, 0, "R11 none");

        // R3 trigger
        wr(12'hF00, 4, 32'h0000_0003, 0, 0, "R3 trigger 3");
        rd(12'h200, 4, 0, 32'h0000_0008, 0, "R3 pends 3");
        wr(12'hF00, 4, 32'h0000_001F, 0, 0, "R3 trigger 31");
        wr(12'hF00, 4, 32'h0000_0020, 0, 0, "R3 trigger 32");
        wr(12'hF00, 4, 32'h0000_01FF, 0, 0, "R3 trigger 511");
        wr(12'hF00, 4, 32'h0000_0202, 0, 0, "R3 high bits ignored");
        rd(12'h200, 4, 0, 32'h8000_000C, 0, "R3 range limit");
        rd(12'hF00, 4, 0, 32'h0, 0, "R3 trigger reads zero");
        wr(12'h280, 4, 32'hFFFF_FFFF, 0, 0, "R5 clear all");

        // R2 trigger gate
        wr(12'hF00, 4, 32'h0000_0006, 1, 1, "R2 closed gate errors");
        rd(12'h200, 4, 0, 32'h0, 0, "R2 closed gate no effect");
        rd(12'hF00, 4, 1, 32'h0, 1, "R2 closed gate read errors");
        wr(12'hD14, 4, 32'h0000_0002, 0, 0, "R2 open gate");
        rd(12'hD14, 4, 0, 32'h0000_0002, 0, "R2 control readback");
        wr(12'hF00, 4, 32'h0000_0006, 1, 0, "R2 open gate accepted");
        rd(12'h200, 4, 0, 32'h0000_0040, 0, "R2 user trigger pends 6");
        rd(12'hD14, 4, 1, 32'h0, 1, "R1 user control read errors");
        wr(12'hF01, 1, 32'h0, 1, 1, "R1 neighbour offset errors");
        wr(12'hD14, 4, 32'h0, 0, 0, "R2 close gate");
        wr(12'hF00, 4, 32'h0000_0007, 1, 1, "R2 reclosed errors");
        rd(12'h200, 4, 0, 32'h0000_0040, 0, "R2 reclosed no effect");

        // R1 unprivileged lockout
        rd(12'h100, 4, 1, 32'h0, 1, "R1 user read");
        wr(12'h180, 4, 32'hFFFF_FFFF, 1, 1, "R1 user clear");
        rd(12'h100, 4, 0, 32'hFFFF_FFFF, 0, "R1 enables unchanged");
        wr(12'h400, 1, 32'h0, 1, 1, "R1 user prio write");
        rd(12'h400, 1, 0, 32'h0000_0010, 0, "R1 prio unchanged");
        wr(12'h200, 4, 32'hFFFF_FFFF, 1, 1, "R1 user pend write");
        rd(12'h200, 4, 0, 32'h0000_0040, 0, "R1 pending unchanged");

        // R8 handler priority bytes
        wr(12'hD18, 4, 32'h4433_2211, 0, 0, "R8 word write");
        rd(12'hD18, 4, 0, 32'h4433_2211, 0, "R8 readback");
        wr(12'hD23, 1, 32'h0000_0099, 0, 0, "R8 last byte");
        rd(12'hD20, 4, 0, 32'h9900_0000, 0, "R8 last byte lane");
        rd(12'hD1A, 2, 0, 32'h0000_4433, 0, "R8 half read");

        // R9 unsupported sizes and addresses
        wr(12'h180, 3, 32'hFFFF_FFFF, 0, 0, "R9 bad size ok");
        rd(12'h100, 4, 0, 32'hFFFF_FFFF, 0, "R9 bad size ignored");
        rd(12'h100, 3, 0, 32'h0, 0, "R9 bad size reads zero");
        rd(12'h700, 4, 0, 32'h0, 0, "R9 unmapped read");
        wr(12'hF00, 2, 32'h0000_0009, 0, 0, "R9 trigger half write ok");
        rd(12'h200, 4, 0, 32'h0000_0040, 0, "R9 trigger half ignored");
        wr(12'hD14, 1, 32'h0000_0002, 0, 0, "R9 control byte write ok");
        rd(12'hD14, 4, 0, 32'h0, 0, "R9 control byte ignored");

        idle();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule